// File: doc/BRIEF.md
# Power-Gated Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transceiver run by one 8-bit mode register. The register carries a master power bit, a transmit enable, a receive enable, a parity selector, a data-length selector and a stop-length selector. The data path takes a transmit byte through a write strobe and drives it onto the serial output line. The serial input is resampled, framed and checked, and the result appears in a receive buffer with a valid flag and three sticky error flags. Bit timing comes from a baud tick supplied from outside. Each bit lasts sixteen ticks.

The block has three levels of shutdown. When the power bit is cleared, the whole serial engine is held in asynchronous reset and is not clocked. The transmit shift state, the receive buffer and the error flags are cleared, and the output line is forced high. Clearing only the transmit enable, or only the receive enable, resets that half on the next clock edge and leaves the other half running.

Top module: `uart_gated`

## Requirements
- R1: After `rst_n` is deasserted, `cfg_rdata` reads 0x01, `txd` is 1, and `tx_busy`, `rx_valid`, `err_parity`, `err_frame` and `err_overrun` are all 0.
- R2: Mode register bit positions: bit 7 power, bit 6 transmit enable, bit 5 receive enable, bits 4:3 parity, bit 2 data length, bit 1 stop length, bit 0 spare. `cfg_wr` loads the whole byte. `cfg_bit_wr` changes only bit `cfg_bit_sel`. When both strobes are asserted in one cycle, the byte write wins.
- R3: A frame is a low start bit, then the data bits LSB first (8 when bit 2 = 1, 7 when bit 2 = 0), then an optional parity bit, then one stop bit (bit 1 = 0) or two stop bits (bit 1 = 1) at level high. Each bit lasts 16 baud ticks. Parity encoding is 00 none, 01 a constant 0, 10 odd (total count of ones is odd), 11 even. The receiver returns the data with unused upper bits as 0.
- R4: While the power bit is 0, `txd` is 1, and `tx_busy`, `rx_valid`, `rx_data` and all error flags are held at 0 asynchronously. The mode register keeps its value.
- R5: A transmit enable of 0 aborts and clears the transmitter at the next clock edge (`tx_busy` 0, `txd` 1). Receive state and the receive buffer are untouched.
- R6: A receive enable of 0 clears the receive buffer, `rx_valid` and the error flags at the next clock edge. A frame already in transmission keeps going.
- R7: The receiver accepts a start bit only if the line is still low 8 ticks after the falling edge was seen. A shorter low pulse produces no frame. Data bits are sampled at mid-bit.
- R8: `err_parity` is set when, in odd or even mode, the received parity bit does not match. In constant-0 mode the parity bit is not checked. `err_frame` is set when the first stop bit is sampled low. In both cases the data is still stored and `rx_valid` is set.
- R9: `err_overrun` is set when a frame completes while `rx_valid` is 1 and `rx_rd` is not asserted in the same cycle. The new data replaces the buffer.
- R10: `err_rd` clears all three error flags. `rx_rd` clears `rx_valid`. If a new error or a new frame lands in the same cycle, it wins over the clear.
- R11: `tx_wr` is accepted only when `tx_busy` is 0 and the power and transmit-enable bits are 1, both in the current register value and in any value written in the same cycle. Otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Whole-byte mode register write |
| cfg_wdata | input | 8 | Byte to write |
| cfg_bit_wr | input | 1 | Single-bit mode register write |
| cfg_bit_sel | input | 3 | Bit index for single-bit write |
| cfg_bit_val | input | 1 | Value for single-bit write |
| cfg_rdata | output | 8 | Mode register readback |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | 8 | Transmit data |
| tx_busy | output | 1 | Frame in transmission |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Receive buffer |
| rx_valid | output | 1 | Receive buffer holds unread data |
| err_rd | input | 1 | Error status read strobe |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |

## Verification
Two functions can fall in the same cycle: a register write that changes the enables, and a transmit write strobe. The bench asserts `tx_wr` in the same cycle as a byte write that clears the transmit enable. It then checks that `tx_busy` stays 0 and that `txd` never leaves high. It also issues a second `tx_wr` while a frame is in flight, and checks that the captured frame carries only the first byte. All frames are decoded from `txd` at mid-bit and compared with a frame the bench builds itself, with parity counted from the number of ones. Each frame is also looped back into `rxd`.

// File: rtl/uart_gated_pkg.sv
package uart_gated_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_e;

  typedef struct packed {
    logic pwr;
    logic txe;
    logic rxe;
    par_e par;
    logic len8;
    logic stop2;
    logic spare;
  } mode_t;

  localparam int FRAME_MAX = 12;

  function automatic int unsigned data_len(mode_t m);
    return m.len8 ? 8 : 7;
  endfunction

  // parity bit sent for a data word under the given mode
  function automatic logic calc_par(par_e p, logic [7:0] d, logic len8);
    logic x;
    x = ^(len8 ? d : {1'b0, d[6:0]});
    case (p)
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      default:  return 1'b0;
    endcase
  endfunction

  // bits after the start bit and before the stop bit(s)
  function automatic logic [3:0] payload_len(mode_t m);
    return 4'(data_len(m) + ((m.par != PAR_NONE) ? 1 : 0));
  endfunction

  function automatic logic [3:0] frame_len(mode_t m);
    return 4'(1 + payload_len(m) + (m.stop2 ? 2 : 1));
  endfunction

  // full frame, bit 0 sent first, unused tail bits are idle-high
  function automatic logic [FRAME_MAX-1:0] make_frame(mode_t m, logic [7:0] d);
    logic [FRAME_MAX-1:0] f;
    int k;
    f = '1;
    f[0] = 1'b0;
    k = 1;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || m.len8) begin
        f[k] = d[i];
        k++;
      end
    end
    if (m.par != PAR_NONE) f[k] = calc_par(m.par, d, m.len8);
    return f;
  endfunction

endpackage

// File: rtl/uart_gated_modereg.sv
module uart_gated_modereg #(
  parameter logic [7:0] RST_VAL = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_we,
  input  logic [7:0] wdata,
  input  logic       bit_we,
  input  logic [2:0] bit_idx,
  input  logic       bit_val,
  output logic [7:0] mode_q,
  output logic [7:0] mode_nxt
);

  always_comb begin
    mode_nxt = mode_q;
    if (byte_we) mode_nxt = wdata;
    else if (bit_we) mode_nxt[bit_idx] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RST_VAL;
    else        mode_q <= mode_nxt;
  end

  // R2
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |=> mode_q == $past(wdata));

endmodule

// File: rtl/uart_gated_tx.sv
module uart_gated_tx
  import uart_gated_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  input  mode_t      mode,
  output logic       txd_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int CW = $clog2(OVS);

  logic [FRAME_MAX-1:0] sh;
  logic [3:0]           left;
  logic [CW-1:0]        tcnt;
  logic                 busy;
  logic                 bit_end;

  assign bit_end = busy & tick & (tcnt == CW'(OVS - 1));
  assign done_o  = bit_end & (left == 4'd1);
  assign txd_o   = busy ? sh[0] : 1'b1;
  assign busy_o  = busy;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh <= '1; left <= '0; tcnt <= '0; busy <= 1'b0;
    end else if (!en) begin
      sh <= '1; left <= '0; tcnt <= '0; busy <= 1'b0;
    end else if (load && !busy) begin
      sh   <= make_frame(mode, din);
      left <= frame_len(mode);
      tcnt <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (bit_end) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FRAME_MAX-1:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

  // R5
  tx_en_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> !busy);

  // R3
  tx_mid_frame_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (en && bit_end && left != 4'd1) |=> busy);

endmodule

// File: rtl/uart_gated_rx.sv
module uart_gated_rx
  import uart_gated_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd,
  input  mode_t      mode,
  input  logic       rd,
  input  logic       err_clr,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       oerr_o,
  output logic       done_o
);

  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  rx_st_e        st;
  logic [CW-1:0] tcnt;
  logic [3:0]    idx;
  logic [8:0]    pl;
  logic          samp, par_bit, par_chk;
  logic          par_bad, frm_bad, ovr_bad;
  logic [7:0]    rx_word;

  assign samp    = tick & (tcnt == CW'(OVS - 1));
  assign done_o  = (st == RX_STOP) & samp;
  assign rx_word = mode.len8 ? pl[7:0] : {1'b0, pl[6:0]};
  assign par_bit = mode.len8 ? pl[8] : pl[7];
  assign par_chk = (mode.par == PAR_ODD) || (mode.par == PAR_EVEN);
  assign par_bad = done_o & par_chk & (par_bit != calc_par(mode.par, rx_word, mode.len8));
  assign frm_bad = done_o & ~rxd;
  assign ovr_bad = done_o & valid_o & ~rd;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st <= RX_IDLE; tcnt <= '0; idx <= '0; pl <= '0; data_o <= '0;
      valid_o <= 1'b0; perr_o <= 1'b0; ferr_o <= 1'b0; oerr_o <= 1'b0;
    end else if (!en) begin
      st <= RX_IDLE; tcnt <= '0; idx <= '0; pl <= '0; data_o <= '0;
      valid_o <= 1'b0; perr_o <= 1'b0; ferr_o <= 1'b0; oerr_o <= 1'b0;
    end else begin
      valid_o <= (valid_o & ~rd) | done_o;
      perr_o  <= (perr_o & ~err_clr) | par_bad;
      ferr_o  <= (ferr_o & ~err_clr) | frm_bad;
      oerr_o  <= (oerr_o & ~err_clr) | ovr_bad;
      if (done_o) data_o <= rx_word;
      case (st)
        RX_IDLE: if (tick && !rxd) begin
          st   <= RX_START;
          tcnt <= '0;
        end
        RX_START: if (tick) begin
          if (tcnt == CW'(HALF - 1)) begin
            tcnt <= '0;
            idx  <= '0;
            st   <= rxd ? RX_IDLE : RX_DATA;
          end else tcnt <= tcnt + CW'(1);
        end
        RX_DATA: if (tick) begin
          if (samp) begin
            pl[idx] <= rxd;
            tcnt    <= '0;
            if (idx == payload_len(mode) - 4'd1) st <= RX_STOP;
            else idx <= idx + 4'd1;
          end else tcnt <= tcnt + CW'(1);
        end
        default: if (tick) begin
          if (samp) begin
            st   <= RX_IDLE;
            tcnt <= '0;
          end else tcnt <= tcnt + CW'(1);
        end
      endcase
    end
  end

  // R8
  parity_flag_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (en && par_bad) |=> perr_o);

  // R9
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (en && done_o && valid_o && !rd) |=> oerr_o);

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (en && err_clr && !done_o) |=> (!perr_o && !ferr_o && !oerr_o));

  // R6
  rx_en_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> (!valid_o && !perr_o && !ferr_o && !oerr_o));

endmodule

// File: rtl/uart_gated.sv
module uart_gated
  import uart_gated_pkg::*;
#(
  parameter int         OVS     = 16,
  parameter logic [7:0] RST_VAL = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  input  logic       cfg_bit_wr,
  input  logic [2:0] cfg_bit_sel,
  input  logic       cfg_bit_val,
  output logic [7:0] cfg_rdata,
  input  logic       baud_tick,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_busy,
  output logic       txd,
  input  logic       rxd,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       err_rd,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun
);

  logic [7:0] mode_raw, nxt_raw;
  mode_t      mode_q, mode_n;
  logic       eng_rst_n;
  logic       tx_accept, tx_line, tx_done, rx_done;
  logic [1:0] rx_sync;

  uart_gated_modereg #(.RST_VAL(RST_VAL)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .byte_we(cfg_wr), .wdata(cfg_wdata),
    .bit_we(cfg_bit_wr), .bit_idx(cfg_bit_sel), .bit_val(cfg_bit_val),
    .mode_q(mode_raw), .mode_nxt(nxt_raw)
  );

  assign mode_q    = mode_t'(mode_raw);
  assign mode_n    = mode_t'(nxt_raw);
  assign cfg_rdata = mode_raw;

  // power bit low holds the whole serial engine in reset
  assign eng_rst_n = rst_n & mode_q.pwr;

  assign tx_accept = tx_wr & ~tx_busy & mode_q.pwr & mode_q.txe & mode_n.pwr & mode_n.txe;

  always_ff @(posedge clk or negedge eng_rst_n) begin
    if (!eng_rst_n) rx_sync <= 2'b11;
    else            rx_sync <= {rx_sync[0], rxd};
  end

  uart_gated_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .arst_n(eng_rst_n), .en(mode_q.txe), .tick(baud_tick),
    .load(tx_accept), .din(tx_data), .mode(mode_q),
    .txd_o(tx_line), .busy_o(tx_busy), .done_o(tx_done)
  );

  uart_gated_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .arst_n(eng_rst_n), .en(mode_q.rxe), .tick(baud_tick),
    .rxd(rx_sync[1]), .mode(mode_q), .rd(rx_rd), .err_clr(err_rd),
    .data_o(rx_data), .valid_o(rx_valid), .perr_o(err_parity),
    .ferr_o(err_frame), .oerr_o(err_overrun), .done_o(rx_done)
  );

  assign txd = mode_q.pwr ? tx_line : 1'b1;

  // R4
  power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.pwr |-> (txd && !tx_busy && !rx_valid && rx_data == 8'h00 &&
                     !err_parity && !err_frame && !err_overrun));

  // R11
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_accept));

  // R3
  tx_idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !tx_done) |-> txd);

endmodule

// File: tb/uart_gated_tb.sv
`timescale 1ns/1ps
module uart_gated_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_bit_wr = 1'b0, cfg_bit_val = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [2:0] cfg_bit_sel = 3'd0;
  logic [7:0] cfg_rdata;
  logic       baud_tick = 1'b0;
  logic [1:0] div = 2'd0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_busy, txd;
  logic       rxd, rxd_drv = 1'b1, lb = 1'b0;
  logic       rx_rd = 1'b0, err_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, err_parity, err_frame, err_overrun;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    div       <= div + 2'd1;
    baud_tick <= (div == 2'd3);
  end

  assign rxd = lb ? txd : rxd_drv;

  uart_gated u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_bit_wr(cfg_bit_wr), .cfg_bit_sel(cfg_bit_sel), .cfg_bit_val(cfg_bit_val),
    .cfg_rdata(cfg_rdata), .baud_tick(baud_tick),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_rd(err_rd), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun)
  );

  // {mode, data}: loopback frames across length/parity/stop settings
  localparam logic [15:0] VEC [6] = '{
    {8'hE4, 8'hA5}, {8'hE0, 8'hD3}, {8'hF4, 8'h3C},
    {8'hFC, 8'h7E}, {8'hEA, 8'h41}, {8'hF2, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected frame, built from the R3 rules with a ones count for parity
  function automatic logic [11:0] bframe(input logic [7:0] m, input logic [7:0] d, output int n);
    logic [11:0] f;
    int dl, ones;
    logic p;
    dl = m[2] ? 8 : 7;
    ones = $countones(m[2] ? d : {1'b0, d[6:0]});
    case (m[4:3])
      2'b10:   p = (ones % 2 == 0);
      2'b11:   p = (ones % 2 == 1);
      default: p = 1'b0;
    endcase
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < dl; i++) f[1 + i] = d[i];
    if (m[4:3] != 2'b00) f[1 + dl] = p;
    n = 1 + dl + ((m[4:3] != 2'b00) ? 1 : 0) + (m[1] ? 2 : 1);
    return f;
  endfunction

  task automatic wait_ticks(input int n);
    int k;
    k = n;
    while (k > 0) begin
      @(negedge clk);
      if (baud_tick) k--;
    end
  endtask

  task automatic cfg_byte(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_bit(input logic [2:0] idx, input logic v);
    @(negedge clk); cfg_bit_wr = 1'b1; cfg_bit_sel = idx; cfg_bit_val = v;
    @(negedge clk); cfg_bit_wr = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rd_pulse;
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic err_pulse;
    @(negedge clk); err_rd = 1'b1;
    @(negedge clk); err_rd = 1'b0;
  endtask

  task automatic capture_tx(input int n, output logic [11:0] got);
    int w;
    w = 0;
    got = '1;
    while (txd !== 1'b0 && w < 400) begin
      @(negedge clk);
      w++;
    end
    wait_ticks(8);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      wait_ticks(16);
      got[i] = txd;
    end
  endtask

  task automatic send_rx(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rxd_drv = f[i];
      wait_ticks(16);
    end
    rxd_drv = 1'b1;
    wait_ticks(2);
  endtask

  task automatic wait_idle;
    int w;
    w = 0;
    while (tx_busy && w < 4000) begin
      @(negedge clk);
      w++;
    end
  endtask

  initial begin
    logic [11:0] f, got;
    int n;
    logic [7:0] m, d;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cfg_rdata", cfg_rdata, 8'h01);
    chk("R1 txd", txd, 1'b1);
    chk("R1 busy/valid/flags", {tx_busy, rx_valid, err_parity, err_frame, err_overrun}, 5'b0);

    // R2 single-bit write and byte-over-bit priority
    cfg_bit(3'd7, 1'b1);
    chk("R2 bit write", cfg_rdata, 8'h81);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'hE4;
    cfg_bit_wr = 1'b1; cfg_bit_sel = 3'd0; cfg_bit_val = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_bit_wr = 1'b0;
    chk("R2 byte wins", cfg_rdata, 8'hE4);

    // R3 loopback table
    lb = 1'b1;
    for (int v = 0; v < 6; v++) begin
      m = VEC[v][15:8];
      d = VEC[v][7:0];
      cfg_byte(m);
      f = bframe(m, d, n);
      tx_write(d);
      capture_tx(n, got);
      chk("R3 tx frame", got, f);
      wait_ticks(24);
      chk("R3 rx valid", rx_valid, 1'b1);
      chk("R3 rx data", rx_data, m[2] ? d : {1'b0, d[6:0]});
      chk("R8 no errors", {err_parity, err_frame, err_overrun}, 3'b0);
      rd_pulse();
      chk("R10 rd clears valid", rx_valid, 1'b0);
    end
    lb = 1'b0;

    // R11 write dropped with power off
    cfg_byte(8'h61);
    tx_write(8'h5A);
    repeat (20) @(negedge clk);
    chk("R11 power off write", {tx_busy, txd}, 2'b01);

    // R11 write in same cycle as txe being cleared
    cfg_byte(8'hE4);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'hA4; tx_wr = 1'b1; tx_data = 8'h0F;
    @(negedge clk);
    cfg_wr = 1'b0; tx_wr = 1'b0;
    begin
      logic low_seen;
      low_seen = 1'b0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (txd == 1'b0 || tx_busy) low_seen = 1'b1;
      end
      chk("R11 same-cycle disable", low_seen, 1'b0);
    end

    // R11 write while busy is dropped
    cfg_byte(8'hE4);
    tx_write(8'h11);
    tx_write(8'h22);
    f = bframe(8'hE4, 8'h11, n);
    capture_tx(n, got);
    chk("R11 busy write dropped", got, f);
    wait_idle();

    // R7 short start pulse rejected
    rxd_drv = 1'b0;
    wait_ticks(4);
    rxd_drv = 1'b1;
    wait_ticks(200);
    chk("R7 false start", {rx_valid, err_parity, err_frame, err_overrun}, 4'b0);

    // R8 parity error in odd mode
    cfg_byte(8'hF4);
    f = bframe(8'hF4, 8'h3C, n);
    f[9] = ~f[9];
    send_rx(f, n);
    chk("R8 parity flag", err_parity, 1'b1);
    chk("R8 data kept", {rx_valid, rx_data}, {1'b1, 8'h3C});
    err_pulse();
    chk("R10 err_rd clears", {err_parity, err_frame, err_overrun}, 3'b0);
    rd_pulse();

    // R8 constant-zero parity is not checked
    cfg_byte(8'hEC);
    f = bframe(8'hEC, 8'h81, n);
    f[9] = 1'b1;
    send_rx(f, n);
    chk("R8 zero parity unchecked", {rx_valid, err_parity, rx_data}, {2'b10, 8'h81});
    rd_pulse();

    // R8 framing error
    cfg_byte(8'hE4);
    f = bframe(8'hE4, 8'h96, n);
    f[9] = 1'b0;
    send_rx(f, n);
    chk("R8 frame flag", {err_frame, rx_valid, rx_data}, {2'b11, 8'h96});
    err_pulse();
    rd_pulse();

    // R6 rx disable clears rx only, tx continues
    f = bframe(8'hE4, 8'h5A, n);
    send_rx(f, n);
    tx_write(8'h33);
    wait_ticks(20);
    cfg_bit(3'd5, 1'b0);
    @(negedge clk);
    chk("R6 rx cleared", {rx_valid, rx_data}, 9'h000);
    chk("R6 tx continues", tx_busy, 1'b1);
    cfg_bit(3'd5, 1'b1);
    wait_idle();

    // R5 tx disable aborts tx only
    send_rx(f, n);
    tx_write(8'h44);
    wait_ticks(20);
    cfg_bit(3'd6, 1'b0);
    @(negedge clk);
    chk("R5 tx aborted", {tx_busy, txd}, 2'b01);
    chk("R5 rx kept", {rx_valid, rx_data}, {1'b1, 8'h5A});
    cfg_bit(3'd6, 1'b1);

    // R9 overrun, new data replaces
    f = bframe(8'hE4, 8'hC3, n);
    send_rx(f, n);
    chk("R9 overrun flag", {err_overrun, rx_data}, {1'b1, 8'hC3});

    // R4 power off mid-frame
    tx_write(8'h55);
    wait_ticks(20);
    cfg_bit(3'd7, 1'b0);
    chk("R4 txd high", txd, 1'b1);
    chk("R4 engine cleared", {tx_busy, rx_valid, err_parity, err_frame, err_overrun}, 5'b0);
    chk("R4 rx buffer cleared", rx_data, 8'h00);
    chk("R4 mode kept", cfg_rdata, 8'h64);
    cfg_bit(3'd7, 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule